// File: doc/BRIEF.md
# Segmented Effective Address Generator

This unit forms the address of a memory operand for a 16-bit processor that uses segmented memory. A five-bit mode word says which terms take part in the offset sum. The terms are a 16-bit displacement, one base register (BX or BP) and one index register (SI or DI). The unit adds the chosen terms modulo 2^16 to form the effective address (the offset).

The unit also picks the default segment from the registers in use. When BP takes part, the stack segment SS is used. In every other legal case, including direct addressing, the data segment DS is used. The physical address is the selected segment value shifted left by four bits plus the offset, kept to 20 bits.

A request is presented with a valid strobe. One clock later the offset, the segment choice and the physical address appear together in output registers, and an output-valid pulse marks them. A mode that names two base registers, two index registers, or no term at all is refused. It raises an error pulse one clock later and leaves the output registers as they were. The mode word lets all seven addressing forms be expressed: direct, base, base plus displacement, base plus index, base plus index plus displacement, index, and index plus displacement.

Top module: `seg_ea_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, out_valid and err are 0 and ea, seg_stack and pa are all 0.
- R2: The mode bits are bit 4 = add disp, bit 3 = add BX, bit 2 = add BP, bit 1 = add SI, bit 0 = add DI. For a legal mode, ea is the sum of exactly the selected terms.
- R3: The offset sum wraps modulo 2^16, and any carry beyond bit 15 is dropped (for example BX=FFFF plus disp=0003 gives 0002).
- R4: seg_stack is 1 (segment taken from SS) when mode bit 2 (BP) is set, and 0 (segment taken from DS) for every other legal mode.
- R5: pa equals (selected segment × 16 + ea) modulo 2^20, where the segment is the DS or SS value sampled with the request.
- R6: A legal request with in_valid=1 updates ea, seg_stack and pa at the next rising clock edge, and out_valid is 1 for exactly that one cycle.
- R7: A request is illegal when mode bits 3 and 2 are both set, when bits 1 and 0 are both set, or when mode is 00000. After an illegal request with in_valid=1, err is 1 for one cycle, out_valid is 0, and ea, seg_stack and pa keep their previous values.
- R8: When in_valid is 0, out_valid and err are 0 in the next cycle and ea, seg_stack and pa keep their values, whatever the other inputs do.
- R9: In direct mode (mode 10000), ea equals disp exactly and the segment is DS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 5 | Term selection {disp, BX, BP, SI, DI} |
| bx | input | 16 | Base register BX |
| bp | input | 16 | Base pointer BP |
| si | input | 16 | Source index SI |
| di | input | 16 | Destination index DI |
| disp | input | 16 | Displacement |
| ds | input | 16 | Data segment value |
| ss | input | 16 | Stack segment value |
| out_valid | output | 1 | Result registers were updated in this cycle |
| err | output | 1 | Last request had an illegal mode |
| ea | output | 16 | Registered effective address (offset) |
| seg_stack | output | 1 | 1 = SS used, 0 = DS used |
| pa | output | 20 | Registered physical address |

## Verification
The bench first uses word-array walks with BX and with SI stepping by two. These show that a register term is really added, and that it is added only when its mode bit is set. Direct mode with non-zero registers shows that unselected registers are masked out. BP forms are paired with DS and SS values that differ, which exposes a wrong segment choice or a wrong shift. Sums and segment-plus-offset values that cross 2^16 and 2^20 catch a wrong carry width. Illegal modes and idle cycles with random inputs change between them, so any output that is not held shows up. A long random run across all 32 mode values then covers the mixtures.

// File: rtl/seg_ea_pkg.sv
package seg_ea_pkg;
  localparam int MODE_W = 5;
  localparam int TERM_N = 5;

  typedef struct packed {
    logic use_disp;
    logic use_bx;
    logic use_bp;
    logic use_si;
    logic use_di;
  } ea_mode_t;

  // One request is refused when both bases or both indexes are named, or nothing is.
  function automatic logic mode_is_legal(ea_mode_t m);
    logic two_bases;
    logic two_index;
    logic empty;
    two_bases = m.use_bx & m.use_bp;
    two_index = m.use_si & m.use_di;
    empty     = (m == '0);
    return !(two_bases || two_index || empty);
  endfunction
endpackage

// File: rtl/seg_ea_decode.sv
module seg_ea_decode
  import seg_ea_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output logic [TERM_N-1:0] term_sel,
  output logic              legal,
  output logic              stack_sel
);
  ea_mode_t m;

  always_comb begin
    m         = ea_mode_t'(mode);
    legal     = mode_is_legal(m);
    stack_sel = m.use_bp;
    term_sel  = {m.use_disp, m.use_bx, m.use_bp, m.use_si, m.use_di};
  end
endmodule

// File: rtl/seg_ea_adder.sv
module seg_ea_adder
  import seg_ea_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  logic [TERM_N-1:0] term_sel,
  input  logic [OFF_W-1:0]  t_disp,
  input  logic [OFF_W-1:0]  t_bx,
  input  logic [OFF_W-1:0]  t_bp,
  input  logic [OFF_W-1:0]  t_si,
  input  logic [OFF_W-1:0]  t_di,
  output logic [OFF_W-1:0]  sum
);
  logic [OFF_W-1:0] terms  [TERM_N];
  logic [OFF_W-1:0] masked [TERM_N];
  logic [OFF_W-1:0] partial[TERM_N+1];

  assign terms[4] = t_disp;
  assign terms[3] = t_bx;
  assign terms[2] = t_bp;
  assign terms[1] = t_si;
  assign terms[0] = t_di;
  assign partial[0] = '0;

  // Carry out of the top bit is dropped by the fixed OFF_W width.
  for (genvar g = 0; g < TERM_N; g++) begin : g_term
    assign masked[g]    = term_sel[g] ? terms[g] : '0;
    assign partial[g+1] = partial[g] + masked[g];
  end

  assign sum = partial[TERM_N];
endmodule

// File: rtl/seg_ea_phys.sv
module seg_ea_phys #(
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PA_W      = 20
) (
  input  logic [OFF_W-1:0] seg_val,
  input  logic [OFF_W-1:0] offset,
  output logic [PA_W-1:0]  pa
);
  function automatic logic [PA_W-1:0] seg_to_pa(logic [OFF_W-1:0] s,
                                                logic [OFF_W-1:0] o);
    logic [PA_W-1:0] base;
    base = PA_W'(s) << SEG_SHIFT;
    return base + PA_W'(o);
  endfunction

  assign pa = seg_to_pa(seg_val, offset);
endmodule

// File: rtl/seg_ea_gen.sv
module seg_ea_gen
  import seg_ea_pkg::*;
#(
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PA_W      = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [MODE_W-1:0] mode,
  input  logic [OFF_W-1:0]  bx,
  input  logic [OFF_W-1:0]  bp,
  input  logic [OFF_W-1:0]  si,
  input  logic [OFF_W-1:0]  di,
  input  logic [OFF_W-1:0]  disp,
  input  logic [OFF_W-1:0]  ds,
  input  logic [OFF_W-1:0]  ss,
  output logic              out_valid,
  output logic              err,
  output logic [OFF_W-1:0]  ea,
  output logic              seg_stack,
  output logic [PA_W-1:0]   pa
);
  // Named internal events for the checker.
  logic [TERM_N-1:0] term_sel;
  logic              term_legal;
  logic              stack_sel;
  logic [OFF_W-1:0]  ea_next;
  logic [OFF_W-1:0]  seg_next;
  logic [PA_W-1:0]   pa_next;
  logic              take_req;
  logic              refuse_req;

  seg_ea_decode u_decode (
    .mode      (mode),
    .term_sel  (term_sel),
    .legal     (term_legal),
    .stack_sel (stack_sel)
  );

  seg_ea_adder #(.OFF_W(OFF_W)) u_adder (
    .term_sel (term_sel),
    .t_disp   (disp),
    .t_bx     (bx),
    .t_bp     (bp),
    .t_si     (si),
    .t_di     (di),
    .sum      (ea_next)
  );

  assign seg_next = stack_sel ? ss : ds;

  seg_ea_phys #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .PA_W(PA_W)) u_phys (
    .seg_val (seg_next),
    .offset  (ea_next),
    .pa      (pa_next)
  );

  assign take_req   = in_valid &  term_legal;
  assign refuse_req = in_valid & ~term_legal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      err       <= 1'b0;
      ea        <= '0;
      seg_stack <= 1'b0;
      pa        <= '0;
    end else begin
      out_valid <= take_req;
      err       <= refuse_req;
      if (take_req) begin
        ea        <= ea_next;
        seg_stack <= stack_sel;
        pa        <= pa_next;
      end
    end
  end
endmodule

// File: rtl/seg_ea_chk.sv
module seg_ea_chk
  import seg_ea_pkg::*;
#(
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PA_W      = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [MODE_W-1:0] mode,
  input logic [OFF_W-1:0]  ds,
  input logic [OFF_W-1:0]  ss,
  input logic              out_valid,
  input logic              err,
  input logic [OFF_W-1:0]  ea,
  input logic              seg_stack,
  input logic [PA_W-1:0]   pa,
  input logic              term_legal
);
  logic bad_mode;
  logic [OFF_W-1:0] ds_d, ss_d;
  logic [PA_W-1:0]  pa_exp;

  assign bad_mode = (mode[3] && mode[2]) || (mode[1] && mode[0]) || (mode == '0);

  always_ff @(posedge clk) begin
    ds_d <= ds;
    ss_d <= ss;
  end

  assign pa_exp = (PA_W'(seg_stack ? ss_d : ds_d) << SEG_SHIFT) + PA_W'(ea);

  // R7 decode agrees with the port-level rule
  p_decode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    term_legal == !bad_mode);

  p_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && bad_mode) |=> (err && !out_valid && $stable(ea) && $stable(pa) && $stable(seg_stack)));

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !bad_mode) |=> (out_valid && !err));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !err && $stable(ea) && $stable(pa) && $stable(seg_stack)));

  p_stack_seg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !bad_mode) |=> (seg_stack == $past(mode[2])));

  p_phys_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pa == pa_exp));

  p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && err));
endmodule

bind seg_ea_gen seg_ea_chk #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .PA_W(PA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .mode       (mode),
  .ds         (ds),
  .ss         (ss),
  .out_valid  (out_valid),
  .err        (err),
  .ea         (ea),
  .seg_stack  (seg_stack),
  .pa         (pa),
  .term_legal (term_legal)
);

// File: tb/seg_ea_gen_bench.sv
`timescale 1ns/1ps
module seg_ea_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  mode = '0;
  logic [15:0] bx = '0, bp = '0, si = '0, di = '0, disp = '0, ds = '0, ss = '0;
  logic        out_valid, err, seg_stack;
  logic [15:0] ea;
  logic [19:0] pa;

  int vectors = 0;
  int miscompares = 0;

  // Reference state
  int unsigned m_ea = 0, m_pa = 0;
  bit m_stack = 0, m_valid = 0, m_err = 0;

  always #10 clk = ~clk;

  seg_ea_gen u_seg_ea_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .bx(bx), .bp(bp), .si(si), .di(di), .disp(disp), .ds(ds), .ss(ss),
    .out_valid(out_valid), .err(err), .ea(ea), .seg_stack(seg_stack), .pa(pa)
  );

  function automatic bit ref_legal(logic [4:0] m);
    if (m == 5'd0) return 0;
    if (m[3] && m[2]) return 0;
    if (m[1] && m[0]) return 0;
    return 1;
  endfunction

  task automatic compare(string tag);
    vectors++;
    if (ea !== 16'(m_ea) || pa !== 20'(m_pa) || seg_stack !== m_stack ||
        out_valid !== m_valid || err !== m_err) begin
      miscompares++;
      $display("FAIL %s: got ea=%h pa=%h stk=%b v=%b e=%b, expected ea=%h pa=%h stk=%b v=%b e=%b",
               tag, ea, pa, seg_stack, out_valid, err,
               16'(m_ea), 20'(m_pa), m_stack, m_valid, m_err);
    end
  endtask

  // Drive at negedge, update model, sample at the following negedge.
  task automatic apply(bit v, logic [4:0] m, logic [15:0] a_bx, logic [15:0] a_bp,
                       logic [15:0] a_si, logic [15:0] a_di, logic [15:0] a_disp,
                       logic [15:0] a_ds, logic [15:0] a_ss, string tag);
    int unsigned sum;
    int unsigned seg;
    in_valid = v; mode = m; bx = a_bx; bp = a_bp; si = a_si; di = a_di;
    disp = a_disp; ds = a_ds; ss = a_ss;
    m_valid = 0; m_err = 0;
    if (v && ref_legal(m)) begin
      sum = 0;
      if (m[4]) sum += a_disp;
      if (m[3]) sum += a_bx;
      if (m[2]) sum += a_bp;
      if (m[1]) sum += a_si;
      if (m[0]) sum += a_di;
      m_ea = sum % 65536;
      m_stack = m[2];
      seg = m[2] ? a_ss : a_ds;
      m_pa = (seg * 16 + m_ea) % 1048576;
      m_valid = 1;
    end else if (v) begin
      m_err = 1;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle_rand(string tag);
    apply(0, 5'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
          16'($urandom), 16'($urandom), 16'($urandom), tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    compare("R1 reset held");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    // R2 word array through BX+disp, stepping by two bytes
    for (int k = 0; k < 5; k++)
      apply(1, 5'b11000, 16'(2*k), 16'h7777, 16'h1111, 16'h2222, 16'h0200,
            16'h1000, 16'h3000, "R2 base+disp walk");
    // R2 register indirect through SI
    for (int k = 0; k < 4; k++)
      apply(1, 5'b00010, 16'h0AAA, 16'h0BBB, 16'(16'h0400 + 2*k), 16'h0CCC, 16'h0055,
            16'h2000, 16'h4000, "R2 index walk");
    apply(1, 5'b10001, 16'h1, 16'h2, 16'h3, 16'h0100, 16'h0002, 16'h1234, 16'h5678, "R2 DI+disp");
    apply(1, 5'b01010, 16'h0300, 16'h9, 16'h0020, 16'h8, 16'h0, 16'h0800, 16'h0900, "R2 BX+SI");
    apply(1, 5'b11001, 16'h0300, 16'h9, 16'h7, 16'h0020, 16'h0004, 16'h0800, 16'h0900, "R2 BX+DI+disp");
    // R9 direct
    apply(1, 5'b10000, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h8088, 16'h0100, 16'h0F00, "R9 direct");
    // R4 BP forms use SS
    apply(1, 5'b00100, 16'h1, 16'h0010, 16'h2, 16'h3, 16'h0, 16'h1000, 16'h2000, "R4 BP");
    apply(1, 5'b10110, 16'h1, 16'h0010, 16'h0004, 16'h3, 16'h0100, 16'h1000, 16'h2000, "R4 BP+SI+disp");
    apply(1, 5'b01001, 16'h0010, 16'h0020, 16'h2, 16'h3, 16'h0, 16'h1000, 16'h2000, "R4 BX+DI on DS");
    // R3 wrap
    apply(1, 5'b11000, 16'hFFFF, 16'h0, 16'h0, 16'h0, 16'h0003, 16'h0000, 16'h0, "R3 wrap");
    apply(1, 5'b11011 & 5'b11010, 16'h8000, 16'h0, 16'h8001, 16'h0, 16'h8000, 16'h0, 16'h0, "R3 triple wrap");
    // R5 physical wrap beyond 20 bits
    apply(1, 5'b10000, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0020, 16'hFFFF, 16'h0, "R5 pa wrap");
    apply(1, 5'b00100, 16'h0, 16'hFFF0, 16'h0, 16'h0, 16'h0, 16'h0, 16'hF001, "R5 pa wrap SS");
    // R7 illegal modes hold outputs
    apply(1, 5'b01100, 16'h1, 16'h2, 16'h3, 16'h4, 16'h5, 16'h6, 16'h7, "R7 two bases");
    apply(1, 5'b10011, 16'h1, 16'h2, 16'h3, 16'h4, 16'h5, 16'h6, 16'h7, "R7 two indexes");
    apply(1, 5'b00000, 16'h1, 16'h2, 16'h3, 16'h4, 16'h5, 16'h6, 16'h7, "R7 empty mode");
    apply(1, 5'b11111, 16'h1, 16'h2, 16'h3, 16'h4, 16'h5, 16'h6, 16'h7, "R7 all set");
    // R8 idle cycles
    for (int k = 0; k < 4; k++) idle_rand("R8 idle hold");
    // R6 back-to-back and mixed
    for (int k = 0; k < 2000; k++) begin
      if (($urandom % 5) == 0) idle_rand("R8 idle mixed");
      else
        apply(1, 5'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
              16'($urandom), 16'($urandom), 16'($urandom), "R6 random request");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule